// File: doc/BRIEF.md
# Protocol Marker and Offset Recorder

This block collects the per-packet results of a multi-round header parser. Each parse round hands it one action. The action sets bits in a 72-bit marker vector and records a 16-bit byte offset against a protocol id. Either half of an action is in single mode, which uses one value taken straight from the action, or in group mode. In group mode the block walks an eight-entry table supplied on its input ports.

A group walk handles one table entry per clock and ends at a sentinel entry or after the eighth entry. The `busy` output is high while further entries remain. Protocol group entries carry their own displacement and sign relative to the current protocol offset. When parsing ends, an emit request makes the block scan the protocol id space from the lowest id upward. It streams out every present (id, offset) pair and then pulses a done strobe together with the number of pairs. A clear input empties the marker vector and the presence flags before the next packet.

Top module: `marker_offset_recorder`

## Requirements
- R1: After reset, `busy`, `outValid` and `outDone` are 0 and `markers` is all zero.
- R2: A single-mode marker id m from 0 to 70 sets bit m of `markers` (byte m/8, bit m mod 8 of the nine-byte vector) on the accepting edge. Id 71 changes nothing. Marker bits only accumulate until a clear.
- R3: A group-mode marker walk takes entries from `markerGrp` (entry i in bits [7i+6:7i]) in index order, one per clock, starting with entry 0 on the accepting edge. It stops at the first entry equal to 71 or after entry 7, and never sets bit 71. `busy` stays high for k cycles when k entries precede a sentinel, and for 7 cycles when there is none.
- R4: A single-mode protocol record stores `actProtoId` (any id 0 to 255) with offset `curPo`.
- R5: A group-mode protocol walk uses entry i with id `protoGrpIds[8i+7:8i]`, displacement `protoGrpOffs[16i+15:16i]` and sign `protoGrpNeg[i]`. It stops at id 0xFF or after entry 7. It stores `curPo + disp` when the sign is 0 and `curPo - disp` when it is 1, both modulo 2^16.
- R6: A later record for an id that is already present replaces its offset, and the id is still emitted only once.
- R7: An emit request produces one `outValid` beat per present id, in strictly ascending id order. A one-cycle `outDone` follows, and `outCount` then equals the number of beats.
- R8: `clearReq` empties the marker vector and all presence flags and aborts any walk or scan. An emission that follows reports a count of 0.
- R9: `actValid` and `emitReq` are ignored while `busy` is high. `emitReq` is also ignored in a cycle in which `actValid` is accepted.
- R10: An action with both halves in single mode completes on its accepting edge and never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clearReq | input | 1 | Clear markers and presence flags, abort activity |
| actValid | input | 1 | Action offered (accepted when not busy) |
| actMarkerGroup | input | 1 | 1: marker group mode, 0: single marker |
| actMarkerId | input | 7 | Single-mode marker id |
| markerGrp | input | 56 | Eight marker group entries, held while busy |
| actProtoGroup | input | 1 | 1: protocol group mode, 0: single protocol |
| actProtoId | input | 8 | Single-mode protocol id |
| curPo | input | 16 | Current protocol offset, held while busy |
| protoGrpIds | input | 64 | Eight protocol group ids |
| protoGrpOffs | input | 128 | Eight displacements |
| protoGrpNeg | input | 8 | Per-entry sign, 1 subtracts |
| emitReq | input | 1 | Start result emission |
| busy | output | 1 | Walk or scan in progress |
| markers | output | 72 | Marker vector |
| outValid | output | 1 | Emitted pair valid |
| outId | output | 8 | Emitted protocol id |
| outOffset | output | 16 | Emitted offset |
| outDone | output | 1 | End of emission pulse |
| outCount | output | 9 | Number of pairs emitted |

## Verification
Marker groups are tried with a sentinel in the middle, with a sentinel in the first entry and with all eight entries live. This separates a correct stop condition from an off-by-one walk, and a mid-walk sample shows whether entries really arrive one per clock. Protocol groups mix added and subtracted displacements, and one of them wraps below zero, which exposes sign and width errors. Repeated ids and the extreme ids 0 and 255 test overwrite behaviour and the ends of the scan. Actions and emit requests offered during a scan or a walk must leave no trace in the marker vector or in the emitted list.

// File: rtl/mor_pkg.sv
package mor_pkg;
  localparam int GRP_N = 8;
  localparam int SEL_W = $clog2(GRP_N);

  typedef struct packed {
    logic clrAll;
    logic mkSet;
    logic prSet;
    logic scanStart;
    logic scanStep;
  } ctl_strobe_t;
endpackage

// File: rtl/mor_ctrl.sv
module mor_ctrl
  import mor_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             actValid,
  input  logic             emitReq,
  input  logic             mkGroup,
  input  logic             prGroup,
  input  logic             mkEnd,
  input  logic             prEnd,
  input  logic             scanLast,
  output logic [SEL_W-1:0] mkSel,
  output logic [SEL_W-1:0] prSel,
  output ctl_strobe_t      strb,
  output logic             busy
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(GRP_N - 1);

  logic             mkRun, prRun, scanRun;
  logic [SEL_W-1:0] mkIdx, prIdx;
  logic             idle, accept, emitGo, mkAct, prAct, mkNext, prNext;

  always_comb begin
    idle   = !mkRun && !prRun && !scanRun;
    accept = actValid && idle && !clearReq;
    emitGo = emitReq && idle && !clearReq && !actValid;
    mkSel  = mkRun ? mkIdx : '0;
    prSel  = prRun ? prIdx : '0;
    mkAct  = (accept || mkRun) && !clearReq;
    prAct  = (accept || prRun) && !clearReq;
    mkNext = mkAct && mkGroup && !mkEnd && (mkSel != LAST_SEL);
    prNext = prAct && prGroup && !prEnd && (prSel != LAST_SEL);
    strb.clrAll    = clearReq;
    strb.mkSet     = mkAct && !mkEnd;
    strb.prSet     = prAct && !prEnd;
    strb.scanStart = emitGo;
    strb.scanStep  = scanRun && !clearReq;
    busy = !idle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mkRun   <= 1'b0;
      prRun   <= 1'b0;
      scanRun <= 1'b0;
      mkIdx   <= '0;
      prIdx   <= '0;
    end else begin
      mkRun <= mkNext;
      prRun <= prNext;
      mkIdx <= mkSel + 1'b1;
      prIdx <= prSel + 1'b1;
      if (clearReq)
        scanRun <= 1'b0;
      else if (emitGo)
        scanRun <= 1'b1;
      else if (scanRun && scanLast)
        scanRun <= 1'b0;
    end
  end
endmodule

// File: rtl/mor_dpath.sv
module mor_dpath
  import mor_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int OFF_W = 16,
  parameter int MK_N  = 72,
  parameter int MK_W  = $clog2(MK_N)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_strobe_t            strb,
  input  logic [SEL_W-1:0]       mkSel,
  input  logic [SEL_W-1:0]       prSel,
  input  logic                   actMarkerGroup,
  input  logic [MK_W-1:0]        actMarkerId,
  input  logic [GRP_N*MK_W-1:0]  markerGrp,
  input  logic                   actProtoGroup,
  input  logic [ID_W-1:0]        actProtoId,
  input  logic [OFF_W-1:0]       curPo,
  input  logic [GRP_N*ID_W-1:0]  protoGrpIds,
  input  logic [GRP_N*OFF_W-1:0] protoGrpOffs,
  input  logic [GRP_N-1:0]       protoGrpNeg,
  output logic                   mkEnd,
  output logic                   prEnd,
  output logic                   scanLast,
  output logic [MK_N-1:0]        markers,
  output logic                   outValid,
  output logic [ID_W-1:0]        outId,
  output logic [OFF_W-1:0]       outOffset,
  output logic                   outDone,
  output logic [ID_W:0]          outCount
);
  localparam int              NUM_ID  = 1 << ID_W;
  localparam logic [MK_W-1:0] MK_NONE = MK_W'(MK_N - 1);
  localparam logic [ID_W-1:0] ID_NONE = {ID_W{1'b1}};

  logic [MK_W-1:0]  mkEntry [GRP_N];
  logic [ID_W-1:0]  prIdEnt [GRP_N];
  logic [OFF_W-1:0] prOffEnt[GRP_N];

  for (genvar g = 0; g < GRP_N; g++) begin : g_unpack
    assign mkEntry[g]  = markerGrp[g*MK_W +: MK_W];
    assign prIdEnt[g]  = protoGrpIds[g*ID_W +: ID_W];
    assign prOffEnt[g] = protoGrpOffs[g*OFF_W +: OFF_W];
  end

  logic [MK_W-1:0]  mkCur;
  logic [ID_W-1:0]  prCur;
  logic [OFF_W-1:0] prVal;

  always_comb begin
    mkCur = actMarkerGroup ? mkEntry[mkSel] : actMarkerId;
    mkEnd = (mkCur == MK_NONE);
    prCur = actProtoGroup ? prIdEnt[prSel] : actProtoId;
    prEnd = actProtoGroup && (prCur == ID_NONE);
    if (!actProtoGroup)
      prVal = curPo;
    else if (protoGrpNeg[prSel])
      prVal = curPo - prOffEnt[prSel];
    else
      prVal = curPo + prOffEnt[prSel];
  end

  // marker vector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      markers <= '0;
    else if (strb.clrAll)
      markers <= '0;
    else if (strb.mkSet)
      markers[mkCur] <= 1'b1;
  end

  // protocol presence and offsets
  logic [NUM_ID-1:0] present;
  logic [OFF_W-1:0]  offTab [NUM_ID];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      present <= '0;
    else if (strb.clrAll)
      present <= '0;
    else if (strb.prSet)
      present[prCur] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.prSet && !strb.clrAll)
      offTab[prCur] <= prVal;
  end

  // ascending scan
  logic [ID_W-1:0] scanIdx;
  logic [ID_W:0]   cnt;

  assign scanLast = (scanIdx == ID_NONE);
  assign outCount = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx   <= '0;
      cnt       <= '0;
      outValid  <= 1'b0;
      outDone   <= 1'b0;
      outId     <= '0;
      outOffset <= '0;
    end else if (strb.clrAll) begin
      outValid <= 1'b0;
      outDone  <= 1'b0;
    end else if (strb.scanStart) begin
      scanIdx  <= '0;
      cnt      <= '0;
      outValid <= 1'b0;
      outDone  <= 1'b0;
    end else if (strb.scanStep) begin
      outValid  <= present[scanIdx];
      outId     <= scanIdx;
      outOffset <= offTab[scanIdx];
      cnt       <= cnt + {{ID_W{1'b0}}, present[scanIdx]};
      scanIdx   <= scanIdx + 1'b1;
      outDone   <= scanLast;
    end else begin
      outValid <= 1'b0;
      outDone  <= 1'b0;
    end
  end
endmodule

// File: rtl/marker_offset_recorder.sv
module marker_offset_recorder
  import mor_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int OFF_W = 16,
  parameter int MK_N  = 72,
  parameter int MK_W  = $clog2(MK_N)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clearReq,
  input  logic                   actValid,
  input  logic                   actMarkerGroup,
  input  logic [MK_W-1:0]        actMarkerId,
  input  logic [GRP_N*MK_W-1:0]  markerGrp,
  input  logic                   actProtoGroup,
  input  logic [ID_W-1:0]        actProtoId,
  input  logic [OFF_W-1:0]       curPo,
  input  logic [GRP_N*ID_W-1:0]  protoGrpIds,
  input  logic [GRP_N*OFF_W-1:0] protoGrpOffs,
  input  logic [GRP_N-1:0]       protoGrpNeg,
  input  logic                   emitReq,
  output logic                   busy,
  output logic [MK_N-1:0]        markers,
  output logic                   outValid,
  output logic [ID_W-1:0]        outId,
  output logic [OFF_W-1:0]       outOffset,
  output logic                   outDone,
  output logic [ID_W:0]          outCount
);
  ctl_strobe_t      strb;
  logic [SEL_W-1:0] mkSel, prSel;
  logic             mkEnd, prEnd, scanLast;

  mor_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .actValid(actValid),
    .emitReq(emitReq), .mkGroup(actMarkerGroup), .prGroup(actProtoGroup),
    .mkEnd(mkEnd), .prEnd(prEnd), .scanLast(scanLast),
    .mkSel(mkSel), .prSel(prSel), .strb(strb), .busy(busy)
  );

  mor_dpath #(.ID_W(ID_W), .OFF_W(OFF_W), .MK_N(MK_N), .MK_W(MK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .mkSel(mkSel), .prSel(prSel),
    .actMarkerGroup(actMarkerGroup), .actMarkerId(actMarkerId),
    .markerGrp(markerGrp), .actProtoGroup(actProtoGroup),
    .actProtoId(actProtoId), .curPo(curPo), .protoGrpIds(protoGrpIds),
    .protoGrpOffs(protoGrpOffs), .protoGrpNeg(protoGrpNeg),
    .mkEnd(mkEnd), .prEnd(prEnd), .scanLast(scanLast), .markers(markers),
    .outValid(outValid), .outId(outId), .outOffset(outOffset),
    .outDone(outDone), .outCount(outCount)
  );
endmodule

// File: rtl/mor_checker.sv
module mor_checker #(
  parameter int ID_W = 8,
  parameter int MK_N = 72
) (
  input logic            clk,
  input logic            rstN,
  input logic            clearReq,
  input logic            actValid,
  input logic            actMarkerGroup,
  input logic            actProtoGroup,
  input logic            busy,
  input logic [MK_N-1:0] markers,
  input logic            outValid,
  input logic [ID_W-1:0] outId,
  input logic            outDone,
  input logic [ID_W:0]   outCount
);
  logic [15:0] beatCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      beatCnt <= '0;
    else if (clearReq || outDone)
      beatCnt <= '0;
    else if (outValid)
      beatCnt <= beatCnt + 16'd1;
  end

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (!busy && markers == '0));

  // R2
  marker_accum_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearReq |=> ((markers & $past(markers)) == $past(markers)));

  // R3
  no_sentinel_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !markers[MK_N-1]);

  // R7
  ascending_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outId > $past(outId)));

  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> (32'(outCount) == 32'(beatCnt) + 32'(outValid)));

  // R10
  single_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && !busy && !clearReq && !actMarkerGroup && !actProtoGroup) |=> !busy);
endmodule

bind marker_offset_recorder mor_checker #(.ID_W(ID_W), .MK_N(MK_N)) u_chk (
  .clk(clk), .rstN(rstN), .clearReq(clearReq), .actValid(actValid),
  .actMarkerGroup(actMarkerGroup), .actProtoGroup(actProtoGroup),
  .busy(busy), .markers(markers), .outValid(outValid), .outId(outId),
  .outDone(outDone), .outCount(outCount)
);

// File: tb/sim_marker_offset_recorder.sv
`timescale 1ns/1ps
module sim_marker_offset_recorder;
  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clearReq = 1'b0, actValid = 1'b0, emitReq = 1'b0;
  logic          actMarkerGroup = 1'b0, actProtoGroup = 1'b0;
  logic [6:0]    actMarkerId = '0;
  logic [55:0]   markerGrp = '0;
  logic [7:0]    actProtoId = '0;
  logic [15:0]   curPo = '0;
  logic [63:0]   protoGrpIds = '0;
  logic [127:0]  protoGrpOffs = '0;
  logic [7:0]    protoGrpNeg = '0;
  logic          busy, outValid, outDone;
  logic [71:0]   markers;
  logic [7:0]    outId;
  logic [15:0]   outOffset;
  logic [8:0]    outCount;

  always #4 clk = ~clk;

  marker_offset_recorder u0 (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .actValid(actValid),
    .actMarkerGroup(actMarkerGroup), .actMarkerId(actMarkerId),
    .markerGrp(markerGrp), .actProtoGroup(actProtoGroup),
    .actProtoId(actProtoId), .curPo(curPo), .protoGrpIds(protoGrpIds),
    .protoGrpOffs(protoGrpOffs), .protoGrpNeg(protoGrpNeg),
    .emitReq(emitReq), .busy(busy), .markers(markers), .outValid(outValid),
    .outId(outId), .outOffset(outOffset), .outDone(outDone), .outCount(outCount)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [71:0] mMk = '0;
  bit          mPres [256];
  logic [15:0] mOff  [256];

  task automatic check(string req, string what, logic [71:0] act, logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doAction(input logic mg, input logic [6:0] mid, input logic [55:0] mtbl,
                          input logic pg, input logic [7:0] pid, input logic [15:0] po,
                          input logic [63:0] ids, input logic [127:0] offs,
                          input logic [7:0] negs, input bit pokeEmit,
                          output int busyCyc, output logic [71:0] firstMk,
                          output int strayOut);
    @(negedge clk);
    actMarkerGroup = mg; actMarkerId = mid; markerGrp = mtbl;
    actProtoGroup = pg; actProtoId = pid; curPo = po;
    protoGrpIds = ids; protoGrpOffs = offs; protoGrpNeg = negs;
    actValid = 1'b1;
    @(negedge clk);
    actValid = 1'b0;
    firstMk = markers;
    busyCyc = 0; strayOut = 0;
    if (pokeEmit) emitReq = 1'b1;
    while (busy && busyCyc < 50) begin
      busyCyc++;
      @(negedge clk);
      if (outValid || outDone) strayOut++;
    end
    emitReq = 1'b0;
    @(negedge clk);
    if (outValid || outDone || busy) strayOut++;
    actMarkerGroup = 1'b0; actProtoGroup = 1'b0;
    // bench model
    if (!mg) begin
      if (mid != 7'd71) mMk[mid] = 1'b1;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (mtbl[i*7 +: 7] == 7'd71) break;
        mMk[mtbl[i*7 +: 7]] = 1'b1;
      end
    end
    if (!pg) begin
      mPres[pid] = 1'b1; mOff[pid] = po;
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] id;
        id = ids[i*8 +: 8];
        if (id == 8'hFF) break;
        mPres[id] = 1'b1;
        mOff[id] = negs[i] ? po - offs[i*16 +: 16] : po + offs[i*16 +: 16];
      end
    end
  endtask

  task automatic runEmit(string req, bit poke);
    int ptr = 0, beats = 0, expCnt = 0;
    bit done = 0;
    for (int i = 0; i < 256; i++) if (mPres[i]) expCnt++;
    @(negedge clk);
    emitReq = 1'b1;
    @(negedge clk);
    emitReq = 1'b0;
    for (int c = 0; c < 400 && !done; c++) begin
      actValid = poke && c >= 1 && c <= 3;
      actMarkerId = 7'd5; actProtoId = 8'd99; curPo = 16'h5555;
      if (outValid) begin
        while (ptr < 256 && !mPres[ptr]) ptr++;
        check(req, "emitted id", 72'(outId), 72'(ptr[7:0]));
        if (ptr < 256) check(req, "emitted offset", 72'(outOffset), 72'(mOff[ptr]));
        ptr++; beats++;
      end
      if (outDone) begin
        done = 1;
        check(req, "count", 72'(outCount), 72'(expCnt));
      end
      @(negedge clk);
    end
    actValid = 1'b0;
    check(req, "done seen", 72'(done), 72'(1));
    check(req, "beats", 72'(beats), 72'(expCnt));
  endtask

  task automatic t_reset;
    check("R1", "busy", 72'(busy), 72'(0));
    check("R1", "markers", markers, 72'(0));
    check("R1", "outValid", 72'(outValid), 72'(0));
    check("R1", "outDone", 72'(outDone), 72'(0));
  endtask

  task automatic t_singleMarker;
    int b, s; logic [71:0] f;
    doAction(0, 7'd0, '0, 0, 8'd0, 16'h0040, '0, '0, '0, 0, b, f, s);
    check("R2", "marker 0", markers, mMk);
    check("R10", "busy cycles", 72'(b), 72'(0));
    doAction(0, 7'd70, '0, 0, 8'd6, 16'h0100, '0, '0, '0, 0, b, f, s);
    doAction(0, 7'd9, '0, 0, 8'd255, 16'hABCD, '0, '0, '0, 0, b, f, s);
    check("R2", "markers 9/70", markers, mMk);
    doAction(0, 7'd71, '0, 0, 8'd6, 16'h0100, '0, '0, '0, 0, b, f, s);
    check("R2", "id 71 no effect", markers, mMk);
    runEmit("R4", 0);
  endtask

  task automatic t_groupMarker;
    int b, s; logic [71:0] f;
    logic [55:0] tb1;
    tb1 = {7'd1, 7'd2, 7'd3, 7'd4, 7'd71, 7'd40, 7'd17, 7'd3};
    doAction(1, 7'd0, tb1, 0, 8'd0, 16'h0000, '0, '0, '0, 0, b, f, s);
    check("R3", "mid-walk bit 3", 72'(f[3]), 72'(1));
    check("R3", "mid-walk bit 17", 72'(f[17]), 72'(0));
    check("R3", "busy cycles sentinel", 72'(b), 72'(3));
    check("R3", "markers", markers, mMk);
    check("R3", "after sentinel bit 4", 72'(markers[4]), 72'(0));
    doAction(1, 7'd0, {7'd71, 7'd60, 7'd61, 7'd62, 7'd63, 7'd64, 7'd65, 7'd71},
             0, 8'd0, 16'h0000, '0, '0, '0, 0, b, f, s);
    check("R3", "leading sentinel busy", 72'(b), 72'(0));
    check("R3", "leading sentinel markers", markers, mMk);
  endtask

  task automatic t_groupProto;
    int b, s; logic [71:0] f;
    doAction(0, 7'd71, '0, 1, 8'd0, 16'h0004,
             {32'hFFFF_FFFF, 8'hFF, 8'd200, 8'd2, 8'd10},
             {64'h0, 16'h0, 16'h0100, 16'h0010, 16'h0010},
             8'b0000_0010, 0, b, f, s);
    check("R5", "busy cycles", 72'(b), 72'(3));
    runEmit("R5", 0);
    // full eight entries on both halves, emit poked while walking
    doAction(1, 7'd0, {7'd57, 7'd56, 7'd55, 7'd54, 7'd53, 7'd52, 7'd51, 7'd50},
             1, 8'd0, 16'h0010,
             {8'd37, 8'd36, 8'd35, 8'd34, 8'd33, 8'd32, 8'd31, 8'd30},
             {8{16'h0001}}, 8'b1010_1010, 1, b, f, s);
    check("R3", "full group busy", 72'(b), 72'(7));
    check("R3", "full group markers", markers, mMk);
    check("R9", "emit ignored while walking", 72'(s), 72'(0));
    runEmit("R7", 0);
  endtask

  task automatic t_overwrite;
    int b, s; logic [71:0] f;
    doAction(0, 7'd71, '0, 0, 8'd2, 16'h0777, '0, '0, '0, 0, b, f, s);
    doAction(0, 7'd71, '0, 1, 8'd0, 16'h0200, {56'hFFFFFFFFFFFFFF, 8'd0},
             {112'h0, 16'h0003}, 8'h01, 0, b, f, s);
    runEmit("R6", 0);
  endtask

  task automatic t_ignore;
    runEmit("R9", 1);
    check("R9", "marker 5 untouched", 72'(markers[5]), 72'(0));
    runEmit("R9", 0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    check("R8", "markers cleared", markers, 72'(0));
    mMk = '0;
    for (int i = 0; i < 256; i++) mPres[i] = 0;
    runEmit("R8", 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mPres[i] = 0; mOff[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_singleMarker();
    t_groupMarker();
    t_groupProto();
    t_overwrite();
    t_ignore();
    t_clear();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule